// File: doc/BRIEF.md
# SPI Register Front End for a UART

This block sits between an SPI host and a UART core. Each exchange is one 16-bit word in both directions at once. The two bits the host sends first name an operation: store the line configuration, fetch it back, hand over a byte to transmit, or collect a received byte. While the host shifts its word in, the block shifts out a response word. That word always begins with the receive-ready and transmit-empty flags. The remaining fourteen bits are either the stored configuration or the received character together with its line status.

The SPI pins are sampled on the system clock through a synchronizer. The bus runs in mode 0: the response's first bit appears when chip select goes low, input bits are taken on rising SCLK, and output bits move on falling SCLK. Each SCLK half-period must last at least SYNC_STAGES + 3 system clocks. On the UART side the block drives the configuration word, a one-cycle transmit strobe with its byte and parity bit, the RTS pin and a one-cycle receive pop. It reads back the status inputs from the core. The receive-ready and transmit-empty flags and the receive status fields are captured when chip select falls.

Top module: `spi_uart_regif`

## Requirements
- R1: A transfer is 16 bits, MSB first, mode 0. A 17th or later SCLK edge within the same selection is ignored.
- R2: Bits 15:14 of the received word select the operation: 2'b11 store configuration, 2'b01 fetch configuration, 2'b10 transmit data, 2'b00 receive data.
- R3: A completed store-configuration transfer copies word bits 13:0 to `cfg_word`. Bit 12 is the shutdown flag, bits 3:0 the baud code, bit 13 the FIFO enable, and bits 11..4 the masks and line options. No other transfer changes `cfg_word`.
- R4: A fetch-configuration response carries the stored configuration in bits 13:0.
- R5: Every response has bit 15 = `rx_avail` and bit 14 = `tx_empty`, both as sampled when chip select fell.
- R6: Receive-data and transmit-data responses carry: bits 7:0 the received byte, bit 8 its parity, bit 9 = NOT `cts_n`, bit 10 = `rx_frame_err` when shutdown (cfg bit 12) is 0 or `rx_active` when it is 1, and bits 13:11 zero. A store-configuration response has bits 13:0 all zero.
- R7: A completed transmit-data transfer with `tx_empty` set at its start sets `rts_n` to the inverse of word bit 9. When word bit 10 is 0, it also pulses `tx_strobe` for one cycle with `tx_data` = bits 7:0 and `tx_parity` = bit 8. When bit 10 is 1, no strobe is issued.
- R8: A transmit-data transfer that starts with `tx_empty` clear issues no strobe and leaves `rts_n` unchanged.
- R9: `rx_pop` pulses for one cycle only when a receive-data or transmit-data transfer completes with `rx_avail` set at its start. It never pulses for configuration operations.
- R10: Chip select rising before the 16th bit discards the transfer: no configuration change, strobe, pop or RTS change.
- R11: After reset, `cfg_word` is 0, `rts_n` is 1, `spi_miso` is 0, and neither strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| cfg_word | output | 14 | Stored line configuration |
| tx_strobe | output | 1 | One-cycle request to send `tx_data` |
| tx_data | output | 8 | Byte to transmit |
| tx_parity | output | 1 | Parity bit to transmit |
| rts_n | output | 1 | RTS pin, active low |
| rx_pop | output | 1 | One-cycle request to consume the received byte |
| rx_avail | input | 1 | Received byte is available |
| tx_empty | input | 1 | Transmit buffer can accept a byte |
| rx_data | input | 8 | Received byte |
| rx_parity | input | 1 | Received parity bit |
| rx_frame_err | input | 1 | Framing error of the received byte |
| rx_active | input | 1 | Receiver line activity seen during shutdown |
| cts_n | input | 1 | CTS pin, active low |

## Verification
Every receive byte value is swept together with varied parity, CTS and framing-error bits. This distinguishes each response field from its neighbours. The sweep is repeated in shutdown to show the bit-10 source switch. Walking-one and mixed configuration words, stored and fetched back, expose any swapped or stuck configuration bit. All four flag combinations are read back. Transmit attempts with the transmit-empty flag set and clear, with the enable bit both ways, and transfers cut short at several bit counts separate accepted, suppressed and discarded operations. Pop pulses are counted across every operation type with the receive-ready flag high and low.

// File: rtl/spi_uart_pkg.sv
package spi_uart_pkg;

    localparam int WORD_W = 16;
    localparam int CFG_W  = 14;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        OP_RX_DATA = 2'b00,
        OP_GET_CFG = 2'b01,
        OP_TX_DATA = 2'b10,
        OP_SET_CFG = 2'b11
    } op_e;

    // field order is fixed by the bit positions the host writes
    typedef struct packed {
        logic       fifo_on;
        logic       shutdown;
        logic       irq_mask_t;
        logic       irq_mask_r;
        logic       irq_mask_p;
        logic       irq_mask_fe;
        logic       ir_timing;
        logic       stop_two;
        logic       par_on;
        logic       len_short;
        logic [3:0] baud_code;
    } line_cfg_t;

endpackage

// File: rtl/spi_uart_sync.sv
module spi_uart_sync #(
    parameter int             N_SIG   = 3,
    parameter int             STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] dout
);

    logic [STAGES-1:0][N_SIG-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_uart_shift.sv
module spi_uart_shift
    import spi_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [1:0]        flags_in,
    input  logic [CFG_W-1:0]  payload,
    output logic              sel_begin,
    output logic              op_known,
    output logic [1:0]        op_bits,
    output logic              word_done,
    output logic [WORD_W-1:0] word_in,
    output logic              miso
);

    typedef struct packed {
        logic              sclk_prev;
        logic              cs_prev;
        logic [WORD_W-1:0] in_sr;
        logic [WORD_W-1:0] out_sr;
        logic [CNT_W-1:0]  cnt;
        logic              hdr;
        logic              done;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      rise, fall;

    assign rise      = sclk_s & ~st_q.sclk_prev;
    assign fall      = ~sclk_s & st_q.sclk_prev;
    assign sel_begin = st_q.cs_prev & ~cs_n_s;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_n_s;
        st_d.hdr       = 1'b0;
        st_d.done      = 1'b0;
        if (cs_n_s) begin
            st_d.cnt    = '0;
            st_d.out_sr = '0;
        end else if (st_q.cs_prev) begin
            st_d.cnt    = '0;
            st_d.in_sr  = '0;
            st_d.out_sr = {flags_in, {CFG_W{1'b0}}};
        end else begin
            if (st_q.hdr) begin
                st_d.out_sr = {st_q.out_sr[WORD_W-1], payload, 1'b0};
            end else if (fall && st_q.cnt != '0) begin
                st_d.out_sr = {st_q.out_sr[WORD_W-2:0], 1'b0};
            end
            if (rise && st_q.cnt < CNT_W'(WORD_W)) begin
                st_d.in_sr = {st_q.in_sr[WORD_W-2:0], mosi_s};
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.hdr   = (st_q.cnt == CNT_W'(1));
                st_d.done  = (st_q.cnt == CNT_W'(WORD_W - 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_known  = st_q.hdr;
    assign op_bits   = st_q.in_sr[1:0];
    assign word_done = st_q.done;
    assign word_in   = st_q.in_sr;
    assign miso      = st_q.out_sr[WORD_W-1];

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(WORD_W));

    assert_deselect_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cs_prev |-> (st_q.cnt == '0 && !st_q.done));

endmodule

// File: rtl/spi_uart_regs.sv
module spi_uart_regs
    import spi_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_begin,
    input  logic              op_known,
    input  logic [1:0]        op_bits,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rx_avail,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_parity,
    input  logic              rx_frame_err,
    input  logic              rx_active,
    input  logic              cts_n,
    output logic [CFG_W-1:0]  payload,
    output logic [CFG_W-1:0]  cfg_word,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_parity,
    output logic              rts_n,
    output logic              rx_pop
);

    typedef struct packed {
        line_cfg_t         cfg;
        logic              snap_r;
        logic              snap_t;
        logic [BYTE_W-1:0] snap_data;
        logic              snap_par;
        logic              snap_cts;
        logic              snap_fe;
        logic              snap_act;
        logic              strobe;
        logic [BYTE_W-1:0] tx_byte;
        logic              tx_par;
        logic              rts;
        logic              pop;
    } reg_st_t;

    reg_st_t st_d, st_q;
    op_e     op_now, op_done;
    logic    status_bit;

    assign op_now     = op_e'(op_bits);
    assign op_done    = op_e'(word_in[WORD_W-1 -: 2]);
    assign status_bit = st_q.cfg.shutdown ? st_q.snap_act : st_q.snap_fe;

    always_comb begin
        unique case (op_now)
            OP_GET_CFG: payload = st_q.cfg;
            OP_SET_CFG: payload = '0;
            default:    payload = {3'b000, status_bit, st_q.snap_cts,
                                   st_q.snap_par, st_q.snap_data};
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.pop    = 1'b0;
        if (sel_begin) begin
            st_d.snap_r    = rx_avail;
            st_d.snap_t    = tx_empty;
            st_d.snap_data = rx_data;
            st_d.snap_par  = rx_parity;
            st_d.snap_cts  = ~cts_n;
            st_d.snap_fe   = rx_frame_err;
            st_d.snap_act  = rx_active;
        end
        if (word_done) begin
            unique case (op_done)
                OP_SET_CFG: st_d.cfg = line_cfg_t'(word_in[CFG_W-1:0]);
                OP_TX_DATA: begin
                    if (st_q.snap_t) begin
                        st_d.rts = word_in[9];
                        if (!word_in[10]) begin
                            st_d.strobe  = 1'b1;
                            st_d.tx_byte = word_in[BYTE_W-1:0];
                            st_d.tx_par  = word_in[8];
                        end
                    end
                end
                default: ;
            endcase
            if ((op_done == OP_TX_DATA || op_done == OP_RX_DATA) && st_q.snap_r) begin
                st_d.pop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_word  = st_q.cfg;
    assign tx_strobe = st_q.strobe;
    assign tx_data   = st_q.tx_byte;
    assign tx_parity = st_q.tx_par;
    assign rts_n     = ~st_q.rts;
    assign rx_pop    = st_q.pop;

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);

    assert_pop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pop |=> !st_q.pop);

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |=> $stable(st_q.cfg));

    assert_rts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |=> $stable(st_q.rts));

    assert_known_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_known |-> !word_done);

endmodule

// File: rtl/spi_uart_regif.sv
module spi_uart_regif
    import spi_uart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [CFG_W-1:0]  cfg_word,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_parity,
    output logic              rts_n,
    output logic              rx_pop,
    input  logic              rx_avail,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_parity,
    input  logic              rx_frame_err,
    input  logic              rx_active,
    input  logic              cts_n
);

    logic [2:0]        pins_s;
    logic              sel_begin, op_known, word_done;
    logic [1:0]        op_bits;
    logic [WORD_W-1:0] word_in;
    logic [CFG_W-1:0]  payload;

    spi_uart_sync #(
        .N_SIG  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout (pins_s)
    );

    spi_uart_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[1]),
        .cs_n_s   (pins_s[2]),
        .mosi_s   (pins_s[0]),
        .flags_in ({rx_avail, tx_empty}),
        .payload  (payload),
        .sel_begin(sel_begin),
        .op_known (op_known),
        .op_bits  (op_bits),
        .word_done(word_done),
        .word_in  (word_in),
        .miso     (spi_miso)
    );

    spi_uart_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_begin   (sel_begin),
        .op_known    (op_known),
        .op_bits     (op_bits),
        .word_done   (word_done),
        .word_in     (word_in),
        .rx_avail    (rx_avail),
        .tx_empty    (tx_empty),
        .rx_data     (rx_data),
        .rx_parity   (rx_parity),
        .rx_frame_err(rx_frame_err),
        .rx_active   (rx_active),
        .cts_n       (cts_n),
        .payload     (payload),
        .cfg_word    (cfg_word),
        .tx_strobe   (tx_strobe),
        .tx_data     (tx_data),
        .tx_parity   (tx_parity),
        .rts_n       (rts_n),
        .rx_pop      (rx_pop)
    );

endmodule

// File: tb/spi_uart_regif_bench.sv
module spi_uart_regif_bench;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso;
    logic [13:0] cfg_word;
    logic        tx_strobe, tx_parity, rts_n, rx_pop;
    logic [7:0]  tx_data;
    logic        rx_avail = 1'b0, tx_empty = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_parity = 1'b0, rx_frame_err = 1'b0, rx_active = 1'b0, cts_n = 1'b1;

    int n_checks = 0, n_errors = 0;
    int n_tx = 0, n_pop = 0;
    logic [7:0] last_tx = 8'h00;
    logic       last_par = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spi_uart_regif u_spi_uart_regif (
        .clk(clk), .rst_n(rst_n),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .cfg_word(cfg_word), .tx_strobe(tx_strobe), .tx_data(tx_data), .tx_parity(tx_parity),
        .rts_n(rts_n), .rx_pop(rx_pop),
        .rx_avail(rx_avail), .tx_empty(tx_empty), .rx_data(rx_data), .rx_parity(rx_parity),
        .rx_frame_err(rx_frame_err), .rx_active(rx_active), .cts_n(cts_n)
    );

    always @(posedge clk) begin
        if (tx_strobe) begin
            n_tx     <= n_tx + 1;
            last_tx  <= tx_data;
            last_par <= tx_parity;
        end
        if (rx_pop) n_pop <= n_pop + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
        r = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = w[15-i];
            wait_clk(HALF);
            r[15-i] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        logic [13:0] cv;
        int tx0, pop0;

        wait_clk(5);
        // R11 reset state
        chk("R11 cfg", cfg_word, 0);
        chk("R11 rts_n", rts_n, 1);
        chk("R11 miso", spi_miso, 0);
        chk("R11 strobes", tx_strobe | rx_pop, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R3 R4 R6 R1: walking one and mixed configuration values
        tx_empty = 1'b1;
        for (int k = 0; k < 16; k++) begin
            cv = (k < 14) ? 14'(1 << k) : ((k == 14) ? 14'h3FFF : 14'h2A5C);
            xfer({2'b11, cv}, 16, r);
            chk("R6 set-cfg response low bits", r[13:0], 0);
            chk("R3 cfg_word", cfg_word, cv);
            xfer({2'b01, 14'h0}, 16, r);
            chk("R4 R1 readback", r[13:0], cv);
        end
        xfer({2'b11, 14'h0}, 16, r);

        // R5 flags in every combination, fetch-config does not pop (R9)
        pop0 = n_pop;
        for (int f = 0; f < 4; f++) begin
            rx_avail = f[1];
            tx_empty = f[0];
            xfer({2'b01, 14'h0}, 16, r);
            chk("R5 flags", r[15:14], f[1:0]);
        end
        chk("R9 no pop on fetch-config", n_pop, pop0);

        // R6 sweep over every receive byte, shutdown clear
        rx_avail = 1'b0;
        tx_empty = 1'b1;
        for (int b = 0; b < 256; b++) begin
            rx_data      = 8'(b);
            rx_parity    = b[0] ^ b[7];
            cts_n        = b[1];
            rx_frame_err = b[2];
            rx_active    = ~b[2];
            xfer({2'b00, 14'h0}, 16, r);
            chk("R6 R2 rx response", r,
                {2'b01, 3'b000, b[2], ~b[1], b[0] ^ b[7], 8'(b)});
        end
        // R6 with shutdown set: bit 10 follows receiver activity
        xfer({2'b11, 14'h1000}, 16, r);
        for (int b = 0; b < 4; b++) begin
            rx_data      = 8'(8'h3C + b);
            rx_frame_err = b[0];
            rx_active    = b[1];
            xfer({2'b00, 14'h0}, 16, r);
            chk("R6 shutdown bit10", r[10], b[1]);
            chk("R6 shutdown data", r[7:0], 8'h3C + b);
        end
        xfer({2'b11, 14'h0}, 16, r);

        // R7 accepted transmit
        for (int b = 0; b < 4; b++) begin
            tx0 = n_tx;
            xfer({2'b10, 3'b000, 1'b0, 1'b1, b[0], 8'(8'hA5 ^ (b * 37))}, 16, r);
            chk("R7 strobe count", n_tx, tx0 + 1);
            chk("R7 tx byte", last_tx, 8'hA5 ^ (b * 37));
            chk("R7 tx parity", last_par, b[0]);
            chk("R7 rts_n asserted", rts_n, 0);
        end
        tx0 = n_tx;
        xfer({2'b10, 3'b000, 1'b1, 1'b0, 1'b0, 8'h77}, 16, r);
        chk("R7 disabled no strobe", n_tx, tx0);
        chk("R7 rts_n released", rts_n, 1);

        // R8 transmit ignored while not empty
        tx_empty = 1'b0;
        xfer({2'b10, 3'b000, 1'b0, 1'b1, 1'b0, 8'h11}, 16, r);
        chk("R8 no strobe", n_tx, tx0);
        chk("R8 rts_n unchanged", rts_n, 1);
        chk("R5 T flag clear", r[14], 0);

        // R9 pop behaviour
        tx_empty = 1'b1;
        rx_avail = 1'b1;
        pop0 = n_pop;
        xfer({2'b00, 14'h0}, 16, r);
        chk("R9 pop on rx-data", n_pop, pop0 + 1);
        xfer({2'b10, 3'b000, 1'b0, 1'b0, 1'b0, 8'h42}, 16, r);
        chk("R9 pop on tx-data", n_pop, pop0 + 2);
        chk("R7 byte with pop", last_tx, 8'h42);
        xfer({2'b11, 14'h0005}, 16, r);
        chk("R9 no pop on set-cfg", n_pop, pop0 + 2);
        rx_avail = 1'b0;
        xfer({2'b00, 14'h0}, 16, r);
        chk("R9 no pop without R", n_pop, pop0 + 2);

        // R10 aborted transfers
        tx0 = n_tx;
        xfer({2'b11, 14'h2222}, 10, r);
        chk("R10 cfg unchanged", cfg_word, 14'h0005);
        xfer({2'b10, 3'b000, 1'b0, 1'b1, 1'b0, 8'h99}, 15, r);
        chk("R10 no strobe", n_tx, tx0);
        chk("R10 rts_n unchanged", rts_n, 1);
        rx_avail = 1'b1;
        xfer({2'b00, 14'h0}, 15, r);
        chk("R10 no pop", n_pop, pop0 + 2);
        xfer({2'b11, 14'h1234}, 16, r);
        chk("R1 full transfer after abort", cfg_word, 14'h1234);

        finish_run();
    end

endmodule